// File: doc/BRIEF.md
# Host Pixel Format Converter

This block sits between the host write path and a frame or texture buffer. Host software writes 32-bit words in any of six source formats: 15-bit, 16-bit, 24-bit or 32-bit RGB, packed YUV 4:4:4, or subsampled YUV 4:2:2. The block emits one pixel per output beat, already laid out in the buffer's programmed RGB depth. As a result, a writer never needs to know how the buffer is organised. Address generation and the memory access itself belong to the neighbouring blocks.

Incoming words are appended to a small byte store. Pixels are cut from the bottom of that store at the source pixel size, so the 24-bit format keeps its byte alignment across word boundaries. Each pixel is first widened to a common 8-bit-per-channel form, converting from YUV where needed. It is then narrowed into the output layout and registered.

Both sides use valid/ready. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. A pixel transfers where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word is held unchanged. That stall propagates back to `in_ready` in the same cycle, through combinational logic. `in_fmt` is a plain control input. `out_fmt` may be changed only while no pixel is in flight.

Top module: `pix_fmt_conv`

## Requirements
- R1: After reset, `out_valid` is low and no pixel appears until a word has been accepted.
- R2: With `in_fmt` 0 (RGB15: R in bits 14:10, G in 9:5, B in 4:0, bit 15 ignored) or 1 (RGB16: R in 15:11, G in 10:5, B in 4:0), each word carries two pixels. Bits 15:0 are emitted first, then bits 31:16.
- R3: With `in_fmt` 2, 24-bit pixels form a byte stream. Word bits 7:0 are the earliest byte. Each pixel is B, then G, then R. Four pixels span three words, and a pixel may straddle two words.
- R4: A 5-bit channel widens to 8 bits as {c, c[4:2]}, and a 6-bit channel widens as {c, c[5:4]}. Sources with no alpha get alpha 255. `in_fmt` 3, and the unused codes 6 and 7, carry {A,R,G,B} from bit 31 down.
- R5: `out_fmt` selects the output layout. Code 0 is {R[7:3],G[7:3],B[7:3]} in bits 14:0. Code 1 is {R[7:3],G[7:2],B[7:3]} in bits 15:0. Code 2 is {R,G,B} in bits 23:0. Code 3 is {A,R,G,B}. Unused upper bits are zero.
- R6: With `in_fmt` 4, Y is in bits 23:16, U in 15:8 and V in 7:0, and bits 31:24 are ignored. Let du = U-128 and dv = V-128. Then R = Y+floor((359·dv+128)/256), G = Y+floor((−88·du−183·dv+128)/256) and B = Y+floor((454·du+128)/256). Each channel saturates to 0..255.
- R7: With `in_fmt` 5, a word holds Y0 in bits 7:0, U in 15:8, Y1 in 23:16 and V in 31:24. It yields two pixels, Y0 first, both converted with the shared U and V as in R6.
- R8: Under back-pressure, a pending output holds its value. No pixel is lost, duplicated or reordered.
- R9: A change of `in_fmt` discards any bytes already received and any pending second YUV 4:2:2 pixel. The block accepts no word in the cycle that follows the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_fmt | input | 3 | Source format code |
| out_fmt | input | 2 | Buffer format code |
| in_valid | input | 1 | Host word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Host word |
| out_valid | output | 1 | Converted pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_data | output | 32 | Converted pixel |

## Verification
Two things can happen in one cycle: a pixel is cut from the bottom of the byte store, and a new word is appended above whatever bytes remain. The 24-bit stream provokes this most often, because a leftover of one or two bytes coexists with an arriving word. The stream is run with `out_ready` held high, so that cut and append coincide on most edges. It is then run again with pseudo-random stalls, so that the two occur both together and apart. Both runs are judged against a pixel list the bench derives from the byte stream. Any misplaced append shows up as a shifted channel in the very next pixel.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
  localparam int CH_W       = 8;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int STORE_BYTES = 2 * WORD_BYTES;
  localparam int STORE_W    = STORE_BYTES * 8;
  localparam int CNT_W      = $clog2(STORE_BYTES + 1);

  typedef enum logic [2:0] {
    IN_RGB15  = 3'd0,
    IN_RGB16  = 3'd1,
    IN_RGB24  = 3'd2,
    IN_RGB32  = 3'd3,
    IN_YUV444 = 3'd4,
    IN_YUV422 = 3'd5,
    IN_RSV6   = 3'd6,
    IN_RSV7   = 3'd7
  } in_fmt_e;

  typedef enum logic [1:0] {
    OUT_RGB15 = 2'd0,
    OUT_RGB16 = 2'd1,
    OUT_RGB24 = 2'd2,
    OUT_RGB32 = 2'd3
  } out_fmt_e;

  typedef struct packed {
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgba_t;

  // bytes taken from the store per source pixel (4:2:2 yields two pixels per 4 bytes)
  function automatic logic [CNT_W-1:0] src_bytes(input in_fmt_e f);
    case (f)
      IN_RGB15, IN_RGB16: return CNT_W'(2);
      IN_RGB24:           return CNT_W'(3);
      default:            return CNT_W'(WORD_BYTES);
    endcase
  endfunction

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic logic [CH_W-1:0] sat8(input int v);
    if (v < 0) return '0;
    else if (v > 255) return '1;
    else return v[CH_W-1:0];
  endfunction
endpackage

// File: rtl/pfc_unpack.sv
module pfc_unpack
  import pix_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  in_fmt_e           fmt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [WORD_W-1:0] pix_bytes,
  output logic              pix_half
);
  logic [STORE_W-1:0] store_q, store_sh, word_ext;
  logic [CNT_W-1:0]   cnt_q, cnt_rem, size;
  logic               half_q;
  in_fmt_e            fmt_q;
  logic               chg, pix_fire, consume, in_fire, is422;

  always_comb begin
    size      = src_bytes(fmt);
    is422     = (fmt == IN_YUV422);
    chg       = (fmt != fmt_q);
    pix_valid = !chg && (cnt_q >= size);
    pix_fire  = pix_valid && pix_ready;
    // the first half of a 4:2:2 word leaves its bytes in place for the second
    consume   = pix_fire && !(is422 && !half_q);
    cnt_rem   = consume ? cnt_q - size : cnt_q;
    store_sh  = consume ? store_q >> {size, 3'b000} : store_q;
    in_ready  = !chg && (cnt_rem < size);
    in_fire   = in_valid && in_ready;
    word_ext  = STORE_W'(in_data) << {cnt_rem, 3'b000};
    pix_bytes = store_q[WORD_W-1:0];
    pix_half  = half_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      fmt_q   <= IN_RGB32;
    end else if (chg) begin
      store_q <= '0;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      fmt_q   <= fmt;
    end else begin
      store_q <= in_fire ? (store_sh | word_ext) : store_sh;
      cnt_q   <= in_fire ? cnt_rem + CNT_W'(WORD_BYTES) : cnt_rem;
      if (pix_fire) half_q <= is422 && !half_q;
    end
  end
endmodule

// File: rtl/pfc_yuv2rgb.sv
module pfc_yuv2rgb
  import pix_fmt_pkg::*;
#(
  parameter int K_RV = 359,
  parameter int K_GU = 88,
  parameter int K_GV = 183,
  parameter int K_BU = 454,
  parameter int FRAC = 8
) (
  input  logic [CH_W-1:0] y,
  input  logic [CH_W-1:0] u,
  input  logic [CH_W-1:0] v,
  output logic [CH_W-1:0] r,
  output logic [CH_W-1:0] g,
  output logic [CH_W-1:0] b
);
  localparam int RND = 1 << (FRAC - 1);
  localparam int MID = 1 << (CH_W - 1);

  int du, dv, yi, ri, gi, bi;

  always_comb begin
    yi = int'(y);
    du = int'(u) - MID;
    dv = int'(v) - MID;
    ri = yi + ((K_RV * dv + RND) >>> FRAC);
    gi = yi + ((-K_GU * du - K_GV * dv + RND) >>> FRAC);
    bi = yi + ((K_BU * du + RND) >>> FRAC);
    r  = sat8(ri);
    g  = sat8(gi);
    b  = sat8(bi);
  end
endmodule

// File: rtl/pfc_decode.sv
module pfc_decode
  import pix_fmt_pkg::*;
(
  input  in_fmt_e           fmt,
  input  logic [WORD_W-1:0] bytes,
  input  logic              half,
  output rgba_t             pix
);
  logic [CH_W-1:0] ysel, usel, vsel, yr, yg, yb;

  pfc_yuv2rgb u_yuv (
    .y(ysel), .u(usel), .v(vsel),
    .r(yr), .g(yg), .b(yb)
  );

  always_comb begin
    if (fmt == IN_YUV422) begin
      ysel = half ? bytes[23:16] : bytes[7:0];
      usel = bytes[15:8];
      vsel = bytes[31:24];
    end else begin
      ysel = bytes[23:16];
      usel = bytes[15:8];
      vsel = bytes[7:0];
    end

    case (fmt)
      IN_RGB15: pix = '{a: '1, r: widen5(bytes[14:10]),
                        g: widen5(bytes[9:5]), b: widen5(bytes[4:0])};
      IN_RGB16: pix = '{a: '1, r: widen5(bytes[15:11]),
                        g: widen6(bytes[10:5]), b: widen5(bytes[4:0])};
      IN_RGB24: pix = '{a: '1, r: bytes[23:16], g: bytes[15:8], b: bytes[7:0]};
      IN_YUV444,
      IN_YUV422: pix = '{a: '1, r: yr, g: yg, b: yb};
      default:  pix = bytes;
    endcase
  end
endmodule

// File: rtl/pfc_out_stage.sv
module pfc_out_stage
  import pix_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  out_fmt_e          fmt,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  rgba_t             pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] packed_w;

  always_comb begin
    pix_ready = !out_valid || out_ready;
    case (fmt)
      OUT_RGB15: packed_w = WORD_W'({pix.r[7:3], pix.g[7:3], pix.b[7:3]});
      OUT_RGB16: packed_w = WORD_W'({pix.r[7:3], pix.g[7:2], pix.b[7:3]});
      OUT_RGB24: packed_w = WORD_W'({pix.r, pix.g, pix.b});
      default:   packed_w = pix;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (pix_ready) begin
      out_valid <= pix_valid;
      if (pix_valid) out_data <= packed_w;
    end
  end
endmodule

// File: rtl/pix_fmt_conv.sv
module pix_fmt_conv
  import pix_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        in_fmt,
  input  logic [1:0]        out_fmt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  in_fmt_e           ifmt;
  out_fmt_e          ofmt;
  logic              pix_valid, pix_ready, pix_half;
  logic [WORD_W-1:0] pix_bytes;
  rgba_t             pix;

  assign ifmt = in_fmt_e'(in_fmt);
  assign ofmt = out_fmt_e'(out_fmt);

  pfc_unpack u_unpack (
    .clk, .rst_n, .fmt(ifmt),
    .in_valid, .in_ready, .in_data,
    .pix_valid, .pix_ready, .pix_bytes, .pix_half
  );

  pfc_decode u_decode (
    .fmt(ifmt), .bytes(pix_bytes), .half(pix_half), .pix
  );

  pfc_out_stage u_out (
    .clk, .rst_n, .fmt(ofmt),
    .pix_valid, .pix_ready, .pix,
    .out_valid, .out_ready, .out_data
  );
endmodule

// File: rtl/pix_fmt_conv_chk.sv
module pix_fmt_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  in_fmt,
  input logic [1:0]  out_fmt,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid);

  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));

  a_r5_rgb15_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_fmt == 2'd0 |-> out_data[31:15] == '0);

  a_r5_rgb24_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_fmt == 2'd2 |-> out_data[31:24] == '0);

  a_r9_switch_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_fmt) |-> !in_ready);
endmodule

bind pix_fmt_conv pix_fmt_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_fmt(in_fmt), .out_fmt(out_fmt),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/pix_fmt_conv_test.sv
module pix_fmt_conv_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  in_fmt;
  logic [1:0]  out_fmt;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_data, out_data;

  int          n_tests = 0;
  int          n_fail  = 0;
  int          rdy_mode = 0;   // 0 always ready, 1 pseudo-random, 2 stalled
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] got_q[$];
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  pix_fmt_conv uut (
    .clk, .rst_n, .in_fmt, .out_fmt, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data
  );

  // consumer: decide ready for the coming edge, then record what will transfer
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = lfsr[0] | lfsr[3];
      default: out_ready = 1'b0;
    endcase
    #1;
    if (rst_n && out_valid && out_ready) got_q.push_back(out_data);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] fi, input logic [1:0] fo);
    @(negedge clk);
    in_valid = 1'b0;
    in_fmt   = fi;
    out_fmt  = fo;
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req);
    int t = 0;
    while (got_q.size() < exp_q.size() && t < 600) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk({req, " pixel count"}, 32'(got_q.size()), 32'(exp_q.size()));
    foreach (exp_q[i])
      chk(req, (i < got_q.size()) ? got_q[i] : 32'hxxxxxxxx, exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  // reference models taken from the requirement text
  function automatic logic [31:0] m15(input logic [15:0] h);
    return {8'hFF, h[14:10], h[14:12], h[9:5], h[9:7], h[4:0], h[4:2]};
  endfunction

  function automatic logic [31:0] m16(input logic [15:0] h);
    return {8'hFF, h[15:11], h[15:13], h[10:5], h[10:9], h[4:0], h[4:2]};
  endfunction

  function automatic logic [7:0] clip(input int v);
    return (v < 0) ? 8'd0 : (v > 255) ? 8'd255 : 8'(v);
  endfunction

  function automatic logic [31:0] myuv(input int y, input int u, input int v);
    int du = u - 128;
    int dv = v - 128;
    return {8'hFF, clip(y + ((359 * dv + 128) >>> 8)),
            clip(y + ((-88 * du - 183 * dv + 128) >>> 8)),
            clip(y + ((454 * du + 128) >>> 8))};
  endfunction

  function automatic logic [31:0] pk(input logic [1:0] fo, input logic [31:0] c);
    case (fo)
      2'd0:    return {17'b0, c[23:19], c[15:11], c[7:3]};
      2'd1:    return {16'b0, c[23:19], c[15:10], c[7:3]};
      2'd2:    return {8'b0, c[23:0]};
      default: return c;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    repeat (3) @(negedge clk);
    chk("R1 no pixel before input", 32'(got_q.size()), 32'd0);
  endtask

  task automatic t_rgb32_all_outputs();
    for (int fo = 0; fo < 4; fo++) begin
      cfg(3'd3, 2'(fo));
      send(32'h80FF4012); send(32'h00_0F_F0_81); idle();
      exp_q.push_back(pk(2'(fo), 32'h80FF4012));
      exp_q.push_back(pk(2'(fo), 32'h000FF081));
      compare("R5 narrowing from RGB32");
    end
    cfg(3'd7, 2'd3);
    send(32'h12345678); idle();
    exp_q.push_back(32'h12345678);
    compare("R4 unused code acts as RGB32");
  endtask

  task automatic t_rgb16();
    cfg(3'd1, 2'd3);
    send({16'h07E0, 16'hF800}); send({16'h001F, 16'h8410}); idle();
    exp_q.push_back(m16(16'hF800)); exp_q.push_back(m16(16'h07E0));
    exp_q.push_back(m16(16'h8410)); exp_q.push_back(m16(16'h001F));
    compare("R2 R4 RGB16 widening order");
    cfg(3'd1, 2'd1);
    send({16'hA5C3, 16'h1234}); idle();
    exp_q.push_back(32'h00001234); exp_q.push_back(32'h0000A5C3);
    compare("R5 RGB16 round trip");
  endtask

  task automatic t_rgb15();
    cfg(3'd0, 2'd2);
    send({16'hFFFF, 16'h4210}); send({16'h8001, 16'h7C00}); idle();
    exp_q.push_back(pk(2'd2, m15(16'h4210))); exp_q.push_back(pk(2'd2, m15(16'hFFFF)));
    exp_q.push_back(pk(2'd2, m15(16'h7C00))); exp_q.push_back(pk(2'd2, m15(16'h8001)));
    compare("R2 RGB15 bit15 ignored");
  endtask

  task automatic t_rgb24(input int mode, input logic [1:0] fo, input string req);
    logic [7:0]  by[24];
    logic [31:0] px[8];
    cfg(3'd2, fo);
    rdy_mode = mode;
    for (int i = 0; i < 8; i++) begin
      px[i] = {8'hFF, 8'(16 * i + 3), 8'(255 - 7 * i), 8'(37 * i + 1)};
      by[3 * i]     = px[i][7:0];
      by[3 * i + 1] = px[i][15:8];
      by[3 * i + 2] = px[i][23:16];
      exp_q.push_back(pk(fo, px[i]));
    end
    for (int k = 0; k < 6; k++)
      send({by[4 * k + 3], by[4 * k + 2], by[4 * k + 1], by[4 * k]});
    idle();
    compare(req);
    rdy_mode = 0;
  endtask

  task automatic t_yuv444();
    int tv[5][3] = '{'{128, 128, 128}, '{255, 128, 255}, '{0, 0, 0},
                     '{81, 90, 240}, '{235, 255, 0}};
    cfg(3'd4, 2'd3);
    foreach (tv[i]) begin
      send({8'hAA, 8'(tv[i][0]), 8'(tv[i][1]), 8'(tv[i][2])});
      exp_q.push_back(myuv(tv[i][0], tv[i][1], tv[i][2]));
    end
    idle();
    compare("R6 YUV444 with saturation");
  endtask

  task automatic t_yuv422();
    cfg(3'd5, 2'd2);
    send({8'd60, 8'd240, 8'd200, 8'd16});
    send({8'd255, 8'd150, 8'd85, 8'd76});
    idle();
    exp_q.push_back(pk(2'd2, myuv(16, 200, 60)));
    exp_q.push_back(pk(2'd2, myuv(240, 200, 60)));
    exp_q.push_back(pk(2'd2, myuv(76, 85, 255)));
    exp_q.push_back(pk(2'd2, myuv(150, 85, 255)));
    compare("R7 YUV422 shared chroma");
  endtask

  task automatic t_fmt_change();
    cfg(3'd2, 2'd3);
    send(32'h44332211); idle();
    exp_q.push_back(32'hFF332211);
    compare("R9 partial 24-bit pixel");
    cfg(3'd3, 2'd3);
    send(32'h01020304); idle();
    exp_q.push_back(32'h01020304);
    compare("R9 leftover byte discarded");
    cfg(3'd5, 2'd3);
    rdy_mode = 2;
    send({8'd128, 8'd200, 8'd128, 8'd50}); idle();
    repeat (3) @(negedge clk);
    in_fmt = 3'd3;
    repeat (3) @(negedge clk);
    rdy_mode = 0;
    send(32'h0A0B0C0D); idle();
    exp_q.push_back(myuv(50, 128, 128));
    exp_q.push_back(32'h0A0B0C0D);
    compare("R9 pending second YUV pixel dropped");
  endtask

  task automatic t_backpressure();
    cfg(3'd1, 2'd3);
    rdy_mode = 1;
    for (int k = 0; k < 10; k++) begin
      logic [15:0] lo = 16'(16'h1357 * (k + 1));
      logic [15:0] hi = 16'(16'hF00D ^ (k * 16'h0911));
      send({hi, lo});
      exp_q.push_back(m16(lo));
      exp_q.push_back(m16(hi));
    end
    idle();
    compare("R8 order under back-pressure");
    rdy_mode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_fmt = 3'd3; out_fmt = 2'd3;
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_rgb32_all_outputs();
    t_rgb16();
    t_rgb15();
    t_rgb24(0, 2'd3, "R3 24-bit packing, free flow");
    t_rgb24(1, 2'd1, "R3 R8 24-bit packing, stalled");
    t_yuv444();
    t_yuv422();
    t_fmt_change();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule